// File: doc/BRIEF.md
# Stuck Bus Detector and Recovery Sequencer

This block watches the synchronized clock and data levels of a two-wire bus and decides when the bus has been held low for too long. It counts the clock cycles in which the two lines are not both high. If that count reaches a full timeout window, the block raises a fault flag. Any single cycle in which both lines are high resets the count and starts the window again.

A static disconnect strap decides what follows a fault. With the strap low, the block only raises the fault flag. With the strap high, it also asks the surrounding buffer to separate the two bus sides. It then leaves the bus alone for a guard interval. After that it pulls the output-side clock low in a burst of up to sixteen pulses, with equal low and high halves. Last, it makes a stop-style event on the data line: data is pulled low while the clock is released, and then data is released. If both lines read high at any point, the block ends recovery at once and clears the fault. If the bus is still stuck after the stop, the fault stays set, the window restarts, and a later expiry runs recovery again.

A global enable holds the whole block inactive while it is low. Nothing in this block carries a data stream, so it has no valid/ready handshake. Every pin is a plain level, and every output is registered.

Top module: `stuck_bus_recovery`

## Requirements
- R1: With the enable high and the sequencer idle, `fault` rises on the clock edge that ends TIMEOUT_CYC consecutive cycles in which `scl_in` and `sda_in` were not both high.
- R2: One cycle with `scl_in` and `sda_in` both high restarts the count from zero, so the next fault needs another full TIMEOUT_CYC cycles.
- R3: When the window expires, `fault` is set whatever the value of `disc_strap`. With `disc_strap` low, `disconnect`, `scl_pull` and `sda_pull` stay low the whole time.
- R4: When the window expires with `disc_strap` high, `disconnect` rises together with `fault`. Both pulls then stay low for exactly WAIT_CYC cycles.
- R5: After the wait, the block makes NPULSE pulses. In each pulse `scl_pull` is 1 for HALF_CYC cycles and then 0 for HALF_CYC cycles. `scl_pull` and `sda_pull` are never 1 together.
- R6: After the last released half, `sda_pull` is 1 for HALF_CYC cycles while `scl_pull` stays 0. Then `sda_pull` returns to 0.
- R7: While `fault` is set, the first edge that sees `scl_in` and `sda_in` both high clears `fault` and `disconnect` and ends any recovery step. It does this in the wait, in a pulse, or in the stop, and all outputs read 0 after that edge.
- R8: If the bus is still stuck once the stop ends, `fault` and `disconnect` stay 1. The window restarts, and after TIMEOUT_CYC more cycles followed by WAIT_CYC cycles, a new pulse burst begins.
- R9: While `en` is low, all four outputs are 0 after the next edge and the window count is held at zero. After `en` rises on a stuck bus, a fault follows a full TIMEOUT_CYC window.
- R10: While `rst_n` is low, and in the cycles after its release on an idle bus, all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global enable; low clears and holds the block |
| disc_strap | input | 1 | 1 = disconnect and run recovery on a fault, 0 = flag only |
| scl_in | input | 1 | Synchronized clock-line level (1 = high) |
| sda_in | input | 1 | Synchronized data-line level (1 = high) |
| fault | output | 1 | Stuck-bus fault flag |
| disconnect | output | 1 | Request to separate the input and output bus sides |
| scl_pull | output | 1 | Open-drain pull-low enable for the output-side clock |
| sda_pull | output | 1 | Open-drain pull-low enable for the output-side data |

## Verification
Some rules can be checked on every cycle, and the checker does so:
- the two pulls are never active together, and no pull happens without a disconnect request;
- a low half never runs longer than HALF_CYC;
- the stop pull starts only from a released clock;
- a fault clears on the edge after the bus reads idle;
- a low enable silences every output.

Other rules can only be shown by the bench scenarios, which compare each output cycle by cycle against an expected timeline. These are the exact length of the timeout window, the restart of that window after one idle cycle, the number and spacing of the pulses, the guard interval, and the second recovery round on a bus that stays stuck.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  // Recovery sequencer phases, in the order they run.
  typedef enum logic [2:0] {
    SEQ_IDLE = 3'd0,
    SEQ_WAIT = 3'd1,
    SEQ_LOW  = 3'd2,
    SEQ_HIGH = 3'd3,
    SEQ_STOP = 3'd4
  } seq_state_t;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sbr_window_timer.sv
// Counts the consecutive cycles in which the bus is not idle (idle = both lines high).
// It fires for one cycle when a full window has passed, then starts a new window.
module sbr_window_timer #(
  parameter int unsigned TIMEOUT_CYC = 9_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bus_high,
  output logic expire
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] busy_cnt;

  assign expire = run && !bus_high && (busy_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (!run || bus_high || expire) begin
      busy_cnt <= '0;
    end else begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sbr_fault_ctrl.sv
// Holds the fault flag and the disconnect request.
// Starts the recovery sequencer when the window expires and the strap allows it.
module sbr_fault_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic expire,
  input  logic strap,
  input  logic bus_high,
  output logic fault,
  output logic disconnect,
  output logic start
);
  assign start = expire && strap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault      <= 1'b0;
      disconnect <= 1'b0;
    end else if (!en || bus_high) begin
      fault      <= 1'b0;
      disconnect <= 1'b0;
    end else begin
      if (expire) fault      <= 1'b1;
      if (start)  disconnect <= 1'b1;
    end
  end

endmodule

// File: rtl/sbr_recovery_seq.sv
// Recovery steps, in order: guard wait, clock pulse burst, then the stop event on the data line.
// It aborts as soon as the bus reads idle.
module sbr_recovery_seq
  import sbr_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 8_000,
  parameter int unsigned HALF_CYC = 18_182,
  parameter int unsigned NPULSE   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic bus_high,
  output logic busy,
  output logic scl_pull,
  output logic sda_pull
);
  localparam int unsigned MAXT = max_of(WAIT_CYC, HALF_CYC);
  localparam int unsigned TW   = $clog2(MAXT + 1);
  localparam int unsigned PW   = $clog2(NPULSE + 1);
  localparam logic [TW-1:0] WAIT_LAST  = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] HALF_LAST  = TW'(HALF_CYC - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(NPULSE - 1);

  seq_state_t    state_q, state_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [PW-1:0] pcnt_q, pcnt_d;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    pcnt_d  = pcnt_q;
    if (!en) begin
      state_d = SEQ_IDLE;
      tcnt_d  = '0;
      pcnt_d  = '0;
    end else if (state_q == SEQ_IDLE) begin
      if (start) begin
        state_d = SEQ_WAIT;
        tcnt_d  = '0;
        pcnt_d  = '0;
      end
    end else if (bus_high) begin
      state_d = SEQ_IDLE;
      tcnt_d  = '0;
      pcnt_d  = '0;
    end else begin
      tcnt_d = tcnt_q + 1'b1;
      unique case (state_q)
        SEQ_WAIT: begin
          if (tcnt_q == WAIT_LAST) begin
            state_d = SEQ_LOW;
            tcnt_d  = '0;
          end
        end
        SEQ_LOW: begin
          if (tcnt_q == HALF_LAST) begin
            state_d = SEQ_HIGH;
            tcnt_d  = '0;
          end
        end
        SEQ_HIGH: begin
          if (tcnt_q == HALF_LAST) begin
            tcnt_d = '0;
            if (pcnt_q == PULSE_LAST) begin
              state_d = SEQ_STOP;
            end else begin
              state_d = SEQ_LOW;
              pcnt_d  = pcnt_q + 1'b1;
            end
          end
        end
        SEQ_STOP: begin
          if (tcnt_q == HALF_LAST) begin
            state_d = SEQ_IDLE;
            tcnt_d  = '0;
            pcnt_d  = '0;
          end
        end
        default: begin
          state_d = SEQ_IDLE;
          tcnt_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      tcnt_q  <= '0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      pcnt_q  <= pcnt_d;
    end
  end

  assign busy     = (state_q != SEQ_IDLE);
  assign scl_pull = (state_q == SEQ_LOW);
  assign sda_pull = (state_q == SEQ_STOP);

endmodule

// File: rtl/stuck_bus_recovery.sv
module stuck_bus_recovery #(
  parameter int unsigned TIMEOUT_CYC = 9_000_000,
  parameter int unsigned WAIT_CYC    = 8_000,
  parameter int unsigned HALF_CYC    = 18_182,
  parameter int unsigned NPULSE      = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic disc_strap,
  input  logic scl_in,
  input  logic sda_in,
  output logic fault,
  output logic disconnect,
  output logic scl_pull,
  output logic sda_pull
);
  logic bus_high;
  logic seq_busy;
  logic win_expire;
  logic seq_start;

  assign bus_high = scl_in && sda_in;

  sbr_window_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (en && !seq_busy),
    .bus_high (bus_high),
    .expire   (win_expire)
  );

  sbr_fault_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .expire     (win_expire),
    .strap      (disc_strap),
    .bus_high   (bus_high),
    .fault      (fault),
    .disconnect (disconnect),
    .start      (seq_start)
  );

  sbr_recovery_seq #(
    .WAIT_CYC (WAIT_CYC),
    .HALF_CYC (HALF_CYC),
    .NPULSE   (NPULSE)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .start    (seq_start),
    .bus_high (bus_high),
    .busy     (seq_busy),
    .scl_pull (scl_pull),
    .sda_pull (sda_pull)
  );

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker #(
  parameter int unsigned HALF_CYC = 18_182
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic disc_strap,
  input logic scl_in,
  input logic sda_in,
  input logic fault,
  input logic disconnect,
  input logic scl_pull,
  input logic sda_pull
);
  localparam int unsigned LW = $clog2(HALF_CYC + 2);

  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= '0;
    else if (scl_pull) low_run <= low_run + 1'b1;
    else               low_run <= '0;
  end

  // R5: the two pulls are never active together
  a_r5_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_pull && sda_pull));

  // R5: a low half never runs longer than HALF_CYC cycles
  a_r5_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> (low_run < LW'(HALF_CYC)));

  // R3: no pull is ever made without a disconnect request
  a_r3_pull_needs_disc: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_pull || sda_pull) |-> disconnect);

  // R4: a disconnect request appears only when the strap was set
  a_r4_disc_from_strap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disconnect) |-> $past(disc_strap));

  // R4: a disconnect request is always paired with the fault flag
  a_r4_disc_with_fault: assert property (@(posedge clk) disable iff (!rst_n)
    disconnect |-> fault);

  // R1: a fault only rises after a cycle in which the bus was not idle
  a_r1_rise_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(!(scl_in && sda_in)));

  // R6: the stop pull starts right after a released clock half
  a_r6_stop_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(!scl_pull));

  // R7: an idle bus clears the fault on the next edge
  a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && scl_in && sda_in) |=> !fault);

  // R9: a low enable silences every output on the next edge
  a_r9_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!fault && !disconnect && !scl_pull && !sda_pull));

endmodule

bind stuck_bus_recovery sbr_checker #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .disc_strap (disc_strap),
  .scl_in     (scl_in),
  .sda_in     (sda_in),
  .fault      (fault),
  .disconnect (disconnect),
  .scl_pull   (scl_pull),
  .sda_pull   (sda_pull)
);

// File: tb/stuck_bus_recovery_tb.sv
`timescale 1ns/1ps
module stuck_bus_recovery_tb;
  localparam int T = 20;   // TIMEOUT_CYC
  localparam int W = 6;    // WAIT_CYC
  localparam int H = 3;    // HALF_CYC
  localparam int N = 16;   // NPULSE

  // Expected output word: {fault, disconnect, scl_pull, sda_pull}
  localparam logic [3:0] E_QUIET = 4'b0000;
  localparam logic [3:0] E_FLAG  = 4'b1000;
  localparam logic [3:0] E_HOLD  = 4'b1100;
  localparam logic [3:0] E_LOW   = 4'b1110;
  localparam logic [3:0] E_STOP  = 4'b1101;

  logic clk = 1'b0;
  logic rst_n, en, disc_strap;
  logic ext_scl_low, ext_sda_low;
  logic scl_in, sda_in;
  logic fault, disconnect, scl_pull, sda_pull;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  // Wired-AND bus model: a line is high unless someone pulls it low.
  assign scl_in = !(ext_scl_low || scl_pull);
  assign sda_in = !(ext_sda_low || sda_pull);

  stuck_bus_recovery #(
    .TIMEOUT_CYC (T),
    .WAIT_CYC    (W),
    .HALF_CYC    (H),
    .NPULSE      (N)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .disc_strap (disc_strap),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .fault      (fault),
    .disconnect (disconnect),
    .scl_pull   (scl_pull),
    .sda_pull   (sda_pull)
  );

  // Driver: push one expected word for each of the next n edges.
  task automatic expect_n(input int n, input logic [3:0] v, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(v);
      tag_q.push_back(tag);
      @(negedge clk);
    end
  endtask

  // Monitor: sample 1 ns after each rising edge and compare with the queue.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        logic [3:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {fault, disconnect, scl_pull, sda_pull};
        vectors++;
        if (a !== e) begin
          miscompares++;
          $display("FAIL %s at %0t: actual %b expected %b (fault,disc,scl,sda)", t, $time, a, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; disc_strap = 1'b0;
    ext_scl_low = 1'b0; ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    // R10: outputs quiet while reset is held
    vectors++;
    if ({fault, disconnect, scl_pull, sda_pull} !== E_QUIET) begin
      miscompares++;
      $display("FAIL R10 in reset: actual %b expected %b",
               {fault, disconnect, scl_pull, sda_pull}, E_QUIET);
    end
    rst_n = 1'b1;
    expect_n(4, E_QUIET, "R10");

    // R1, R3: strap low, data stuck -> flag only
    ext_sda_low = 1'b1;
    expect_n(T - 1, E_QUIET, "R1");
    expect_n(1, E_FLAG, "R1");
    expect_n(2 * T, E_FLAG, "R3");
    ext_sda_low = 1'b0;
    expect_n(3, E_QUIET, "R7");

    // R2: one idle cycle restarts the window
    ext_scl_low = 1'b1;
    expect_n(T - 2, E_QUIET, "R2");
    ext_scl_low = 1'b0;
    expect_n(1, E_QUIET, "R2");
    ext_scl_low = 1'b1;
    expect_n(T - 1, E_QUIET, "R2");
    expect_n(1, E_FLAG, "R2");
    ext_scl_low = 1'b0;
    expect_n(2, E_QUIET, "R7");

    // R7: strap high, bus releases during the second pulse
    disc_strap = 1'b1;
    ext_sda_low = 1'b1;
    expect_n(T - 1, E_QUIET, "R1");
    expect_n(W, E_HOLD, "R4");
    expect_n(H, E_LOW, "R5");
    expect_n(H, E_HOLD, "R5");
    expect_n(1, E_LOW, "R5");
    ext_sda_low = 1'b0;
    expect_n(H - 1, E_LOW, "R7");
    expect_n(1, E_HOLD, "R7");
    expect_n(4, E_QUIET, "R7");

    // R5, R6, R8: full recovery on a bus that stays stuck
    ext_sda_low = 1'b1;
    expect_n(T - 1, E_QUIET, "R1");
    expect_n(W, E_HOLD, "R4");
    for (int p = 0; p < N; p++) begin
      expect_n(H, E_LOW, "R5");
      expect_n(H, E_HOLD, "R5");
    end
    expect_n(H, E_STOP, "R6");
    expect_n(T + W, E_HOLD, "R8");
    expect_n(2, E_LOW, "R8");

    // R9: enable low clears and holds; raising it on a stuck bus waits a full window
    en = 1'b0;
    expect_n(2 * T, E_QUIET, "R9");
    en = 1'b1;
    expect_n(T - 1, E_QUIET, "R9");
    expect_n(1, E_HOLD, "R9");
    ext_sda_low = 1'b0;
    expect_n(3, E_QUIET, "R7");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule